// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the per-warp control-flow stack that a SIMT core uses to run divergent branches one path at a time. Each entry records three things: the PC at which the entry's threads rejoin (reconvergence PC), the PC the entry will run next, and the mask of threads that are active in it. The top entry drives the warp. Its next PC and active mask are the block's outputs. No separate mask register exists. The mask lives only in the stack entries.

Two kinds of events arrive each cycle. A step event reports the PC the warp moves to after a non-branch instruction. A branch event carries a taken mask, a taken target, a fall-through PC and the reconvergence PC computed elsewhere. When the branch diverges, the current entry is parked at the reconvergence PC with its full mask. The not-taken path is pushed below the taken path, so the taken path runs first. When the top entry's next PC reaches its reconvergence PC, that entry is popped. Paths that hold no threads are never pushed. Paths that would start at the reconvergence point are also never pushed.

After reset the stack holds a single bottom entry. That entry starts at a parameter PC with all 32 threads active and carries the all-ones PC as a reconvergence value that is never reached. Depth is a parameter. A push beyond it sets a sticky overflow flag.

Top module: `simt_reconv_stack`

## Requirements
- R1: After synchronous reset the outputs are as follows: stack level 1, next PC equal to the START_PC parameter, all 32 mask bits set, overflow flag 0. Bit i of a mask is thread i.
- R2: A step event whose PC differs from the top entry's reconvergence PC changes the next PC on the following cycle. The active mask and level stay the same.
- R3: A branch whose taken mask covers every active thread sets the next PC to the target. A branch that takes no active thread sets it to the fall-through PC. Neither case pushes an entry or changes the mask.
- R4: A divergent branch parks the current entry at the reconvergence PC and pushes the not-taken entry, then the taken entry (level +2). The next cycle shows the target PC and the mask (taken AND active).
- R5: When the top entry's next PC becomes equal to its reconvergence PC, it is popped. The not-taken path then appears, with the fall-through PC and the mask (active AND NOT taken).
- R6: When the not-taken path reaches the reconvergence PC, it is popped. The parked entry then appears with the reconvergence PC and the full pre-branch mask.
- R7: On a divergent branch, a path whose start PC equals the reconvergence PC is not pushed.
- R8: A divergent branch whose reconvergence PC equals the top entry's own reconvergence PC replaces the top entry instead of parking it (net level +1).
- R9: If a push would take the level above DEPTH, the level saturates at DEPTH and the pushes beyond it are dropped. The overflow flag is then set and stays set until reset.
- R10: When step and branch events arrive in the same cycle, the branch is applied and the step is ignored.
- R11: Taken-mask bits of threads that are not active are ignored when the branch is classified.
- R12: Step, target, fall-through and reconvergence PCs must never be all ones. That value marks the bottom entry, so the level never drops below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Non-branch advance event |
| step_pc | input | 32 | PC after the current instruction |
| br_valid | input | 1 | Conditional branch event |
| br_taken_mask | input | 32 | Threads taking the branch |
| br_target | input | 32 | Taken-path PC |
| br_fallthru | input | 32 | Not-taken-path PC |
| br_reconv | input | 32 | Reconvergence PC of the branch |
| next_pc | output | 32 | Next PC of the top entry |
| active_mask | output | 32 | Active threads of the top entry |
| stack_level | output | $clog2(DEPTH+3) | Number of valid entries |
| overflow | output | 1 | Sticky depth-overflow flag |

## Verification
The directed phase drives a fixed set of branch masks: all active threads taken, none taken, an even split, a split where one path starts at the reconvergence point, a nested split that shares its parent's reconvergence PC, and a taken mask with stray inactive bits. Each case separates one push or replace decision from the others through the level and mask it leaves. Pops are driven by step PCs that hit the reconvergence PC, which shows that entries resurface in the right order with the right masks. A randomized phase draws PCs from a small pool so that equalities between PCs happen often, mixes split and uniform masks, and runs into the depth limit. A queue-based reference model follows every cycle.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;
    localparam int WARP_W = 32;
    localparam int PC_W   = 32;
    localparam int N_WR   = 3;

    typedef logic [WARP_W-1:0] mask_t;
    typedef logic [PC_W-1:0]   pc_t;

    typedef struct packed {
        pc_t   rpc;
        pc_t   npc;
        mask_t mask;
    } stk_ent_t;

    localparam pc_t NO_RECONV = '1;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_ALL_TAKEN,
        BR_ALL_FALL,
        BR_SPLIT
    } br_kind_e;

    function automatic br_kind_e classify(logic valid, mask_t taken, mask_t active);
        if (!valid)                        return BR_NONE;
        if ((active & ~taken) == '0)       return BR_ALL_TAKEN;
        if ((active & taken) == '0)        return BR_ALL_FALL;
        return BR_SPLIT;
    endfunction

    function automatic stk_ent_t mk_ent(pc_t r, pc_t n, mask_t m);
        stk_ent_t e;
        e.rpc  = r;
        e.npc  = n;
        e.mask = m;
        return e;
    endfunction
endpackage

// File: rtl/simt_stk_mem.sv
module simt_stk_mem
    import simt_stk_pkg::*;
#(
    parameter int       DEPTH       = 8,
    parameter int       LVL_W       = 4,
    parameter stk_ent_t BOTTOM_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en  [N_WR],
    input  logic [LVL_W-1:0] wr_idx [N_WR],
    input  stk_ent_t         wr_ent [N_WR],
    input  logic [LVL_W-1:0] rd_idx,
    output stk_ent_t         rd_ent
);
    localparam int EW = $bits(stk_ent_t);

    logic [DEPTH*EW-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam stk_ent_t INIT = (g == 0) ? BOTTOM_INIT : stk_ent_t'('0);
        stk_ent_t slot;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot <= INIT;
            end else begin
                // later ports win; the controller never aims two ports at one slot
                for (int w = 0; w < N_WR; w++) begin
                    if (wr_en[w] && wr_idx[w] == LVL_W'(g)) slot <= wr_ent[w];
                end
            end
        end
        assign flat[g*EW +: EW] = slot;
    end

    always_comb begin
        rd_ent = flat[0 +: EW];
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == LVL_W'(i)) rd_ent = flat[i*EW +: EW];
        end
    end
endmodule

// File: rtl/simt_stk_ctrl.sv
module simt_stk_ctrl
    import simt_stk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic             [LVL_W-1:0] level,
    input  stk_ent_t                     top_ent,
    input  logic                         step_valid,
    input  pc_t                          step_pc,
    input  logic                         br_valid,
    input  mask_t                        br_taken_mask,
    input  pc_t                          br_target,
    input  pc_t                          br_fallthru,
    input  pc_t                          br_reconv,
    output logic                         wr_en  [N_WR],
    output logic             [LVL_W-1:0] wr_idx [N_WR],
    output stk_ent_t                     wr_ent [N_WR],
    output logic             [LVL_W-1:0] level_next,
    output logic                         ovf_set
);
    localparam logic [LVL_W-1:0] ONE = LVL_W'(1);
    localparam logic [LVL_W-1:0] CAP = LVL_W'(DEPTH);

    br_kind_e         kind;
    mask_t            tk_mask, nt_mask;
    logic             go_valid;
    pc_t              go_pc;
    logic             keep, push_nt, push_tk;
    logic [LVL_W-1:0] top_idx, base, nt_step, tk_step, raw;

    always_comb begin
        kind     = classify(br_valid, br_taken_mask, top_ent.mask);
        tk_mask  = br_taken_mask & top_ent.mask;
        nt_mask  = top_ent.mask & ~br_taken_mask;
        top_idx  = level - ONE;

        go_valid = 1'b0;
        go_pc    = step_pc;
        case (kind)
            BR_ALL_TAKEN: begin go_valid = 1'b1; go_pc = br_target;   end
            BR_ALL_FALL:  begin go_valid = 1'b1; go_pc = br_fallthru; end
            BR_NONE:      begin go_valid = step_valid; go_pc = step_pc; end
            default:      ;
        endcase

        // split bookkeeping: park current entry unless it already waits at this point
        keep    = (top_ent.rpc != br_reconv);
        push_nt = (br_fallthru != br_reconv);
        push_tk = (br_target != br_reconv);
        base    = keep ? level : top_idx;
        nt_step = {{(LVL_W-1){1'b0}}, push_nt};
        tk_step = {{(LVL_W-1){1'b0}}, push_tk};
        raw     = base + nt_step + tk_step;

        for (int w = 0; w < N_WR; w++) begin
            wr_en[w]  = 1'b0;
            wr_idx[w] = top_idx;
            wr_ent[w] = top_ent;
        end
        level_next = level;
        ovf_set    = 1'b0;

        if (kind == BR_SPLIT) begin
            wr_en[0]  = keep;
            wr_ent[0] = mk_ent(top_ent.rpc, br_reconv, top_ent.mask);
            wr_en[1]  = push_nt;
            wr_idx[1] = base;
            wr_ent[1] = mk_ent(br_reconv, br_fallthru, nt_mask);
            wr_en[2]  = push_tk;
            wr_idx[2] = base + nt_step;
            wr_ent[2] = mk_ent(br_reconv, br_target, tk_mask);
            if (raw > CAP) begin
                level_next = CAP;
                ovf_set    = 1'b1;
            end else begin
                level_next = raw;
            end
        end else if (go_valid) begin
            if (go_pc == top_ent.rpc) begin
                level_next = top_idx;
            end else begin
                wr_en[0]  = 1'b1;
                wr_ent[0] = mk_ent(top_ent.rpc, go_pc, top_ent.mask);
            end
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stk_pkg::*;
#(
    parameter int          DEPTH    = 8,
    parameter logic [31:0] START_PC = 32'h0000_0100,
    localparam int         LVL_W    = $clog2(DEPTH + 3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_valid,
    input  logic [31:0]      step_pc,
    input  logic             br_valid,
    input  logic [31:0]      br_taken_mask,
    input  logic [31:0]      br_target,
    input  logic [31:0]      br_fallthru,
    input  logic [31:0]      br_reconv,
    output logic [31:0]      next_pc,
    output logic [31:0]      active_mask,
    output logic [LVL_W-1:0] stack_level,
    output logic             overflow
);
    localparam stk_ent_t BOTTOM = stk_ent_t'({NO_RECONV, pc_t'(START_PC), {WARP_W{1'b1}}});

    logic [LVL_W-1:0] level_q, level_d;
    logic             ovf_q, ovf_set;
    stk_ent_t         top_ent;
    logic             wr_en  [N_WR];
    logic [LVL_W-1:0] wr_idx [N_WR];
    stk_ent_t         wr_ent [N_WR];

    simt_stk_mem #(
        .DEPTH      (DEPTH),
        .LVL_W      (LVL_W),
        .BOTTOM_INIT(BOTTOM)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wr_idx(wr_idx),
        .wr_ent(wr_ent),
        .rd_idx(level_q - LVL_W'(1)),
        .rd_ent(top_ent)
    );

    simt_stk_ctrl #(
        .DEPTH(DEPTH),
        .LVL_W(LVL_W)
    ) u_ctrl (
        .level        (level_q),
        .top_ent      (top_ent),
        .step_valid   (step_valid),
        .step_pc      (step_pc),
        .br_valid     (br_valid),
        .br_taken_mask(br_taken_mask),
        .br_target    (br_target),
        .br_fallthru  (br_fallthru),
        .br_reconv    (br_reconv),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_ent       (wr_ent),
        .level_next   (level_d),
        .ovf_set      (ovf_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= LVL_W'(1);
            ovf_q   <= 1'b0;
        end else begin
            level_q <= level_d;
            if (ovf_set) ovf_q <= 1'b1;
        end
    end

    assign next_pc     = top_ent.npc;
    assign active_mask = top_ent.mask;
    assign stack_level = level_q;
    assign overflow    = ovf_q;

    // R12: the bottom entry is never popped
    p_level_nonzero_r12: assert property (@(posedge clk) disable iff (rst)
        stack_level != '0);

    // R9: level saturates at the configured depth
    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
        stack_level <= LVL_W'(DEPTH));

    // R9: overflow stays set once raised
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R2: a lone step never grows the stack
    p_step_no_push_r2: assert property (@(posedge clk) disable iff (rst)
        (step_valid && !br_valid) |=> stack_level <= $past(stack_level));

    // R3: a branch taken by every active thread never grows the stack
    p_uniform_no_push_r3: assert property (@(posedge clk) disable iff (rst)
        (br_valid && ((br_taken_mask & active_mask) == active_mask))
        |=> stack_level <= $past(stack_level));

    // R4: a path pushed by a branch only holds threads that were active
    p_push_subset_r4: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> (!(stack_level > $past(stack_level))
                      || ((active_mask & ~$past(active_mask)) == '0)));
endmodule

// File: tb/simt_reconv_stack_bench.sv
module simt_reconv_stack_bench;
    import simt_stk_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 4;
    localparam int          LVL_W      = $clog2(DEPTH + 3);
    localparam logic [31:0] START_PC   = 32'h100;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             step_valid = 1'b0;
    logic [31:0]      step_pc = '0;
    logic             br_valid = 1'b0;
    logic [31:0]      br_taken_mask = '0, br_target = '0, br_fallthru = '0, br_reconv = '0;
    logic [31:0]      next_pc, active_mask;
    logic [LVL_W-1:0] stack_level;
    logic             overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_reconv_stack #(.DEPTH(DEPTH), .START_PC(START_PC)) u_simt_reconv_stack (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_pc(step_pc),
        .br_valid(br_valid), .br_taken_mask(br_taken_mask), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv), .next_pc(next_pc),
        .active_mask(active_mask), .stack_level(stack_level), .overflow(overflow)
    );

    // behavioural reference: a queue whose back is the top of the stack
    stk_ent_t model_q[$];
    bit       model_ovf;

    function automatic void m_push(stk_ent_t e);
        if (model_q.size() < DEPTH) model_q.push_back(e);
        else model_ovf = 1;
    endfunction

    function automatic void m_goto(pc_t p);
        stk_ent_t t;
        t = model_q[model_q.size()-1];
        if (p == t.rpc) begin
            void'(model_q.pop_back());
        end else begin
            t.npc = p;
            model_q[model_q.size()-1] = t;
        end
    endfunction

    function automatic void m_apply(bit sv, pc_t sp, bit bv, mask_t tm_in, pc_t tg, pc_t ft, pc_t rc);
        stk_ent_t t;
        mask_t tm, nm;
        t  = model_q[model_q.size()-1];
        tm = tm_in & t.mask;
        nm = t.mask & ~tm_in;
        if (bv) begin
            if (nm == 0) m_goto(tg);
            else if (tm == 0) m_goto(ft);
            else begin
                if (t.rpc == rc) void'(model_q.pop_back());
                else begin
                    t.npc = rc;
                    model_q[model_q.size()-1] = t;
                end
                if (ft != rc) m_push(mk_ent(rc, ft, nm));
                if (tg != rc) m_push(mk_ent(rc, tg, tm));
            end
        end else if (sv) begin
            m_goto(sp);
        end
    endfunction

    task automatic compare(string tag);
        stk_ent_t t;
        t = model_q[model_q.size()-1];
        checks++;
        if (next_pc !== t.npc || active_mask !== t.mask ||
            stack_level !== LVL_W'(model_q.size()) || overflow !== model_ovf) begin
            fails++;
            $display("FAIL %s: got pc=%h mask=%h lvl=%0d ovf=%0b exp pc=%h mask=%h lvl=%0d ovf=%0b",
                     tag, next_pc, active_mask, stack_level, overflow,
                     t.npc, t.mask, model_q.size(), model_ovf);
        end
    endtask

    task automatic expect_out(string tag, logic [31:0] pc, logic [31:0] m, int lvl, bit ovf);
        checks++;
        if (next_pc !== pc || active_mask !== m || stack_level !== LVL_W'(lvl) || overflow !== ovf) begin
            fails++;
            $display("FAIL %s: got pc=%h mask=%h lvl=%0d ovf=%0b exp pc=%h mask=%h lvl=%0d ovf=%0b",
                     tag, next_pc, active_mask, stack_level, overflow, pc, m, lvl, ovf);
        end
    endtask

    task automatic cyc(string tag, bit sv, logic [31:0] sp, bit bv,
                       logic [31:0] tm, logic [31:0] tg, logic [31:0] ft, logic [31:0] rc);
        step_valid = sv; step_pc = sp; br_valid = bv;
        br_taken_mask = tm; br_target = tg; br_fallthru = ft; br_reconv = rc;
        @(posedge clk);
        m_apply(sv, sp, bv, tm, tg, ft, rc);
        @(negedge clk);
        step_valid = 0; br_valid = 0;
        compare(tag);
    endtask

    task automatic step(string tag, logic [31:0] p);
        cyc(tag, 1, p, 0, '0, '0, '0, '0);
    endtask

    task automatic branch(string tag, logic [31:0] tm, logic [31:0] tg, logic [31:0] ft, logic [31:0] rc);
        cyc(tag, 0, '0, 1, tm, tg, ft, rc);
    endtask

    task automatic do_reset();
        rst = 1; step_valid = 0; br_valid = 0;
        repeat (2) @(posedge clk);
        model_q.delete();
        model_q.push_back(mk_ent(NO_RECONV, START_PC, '1));
        model_ovf = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_out("R1", START_PC, 32'hFFFF_FFFF, 1, 0);
    endtask

    function automatic logic [31:0] rpc_pick();
        return 32'h1000 + 32'(($urandom % 8) * 4);
    endfunction

    initial begin
        do_reset();
        // R2: plain steps
        step("R2", 32'h104);  expect_out("R2", 32'h104, 32'hFFFF_FFFF, 1, 0);
        step("R2", 32'h108);
        // R3: uniform taken, uniform fall-through
        branch("R3", 32'hFFFF_FFFF, 32'h200, 32'h10C, 32'h300);
        expect_out("R3", 32'h200, 32'hFFFF_FFFF, 1, 0);
        branch("R3", 32'h0, 32'h280, 32'h204, 32'h300);
        expect_out("R3", 32'h204, 32'hFFFF_FFFF, 1, 0);
        // R4..R6: split, taken first, then not-taken, then rejoin
        branch("R4", 32'h0000_FFFF, 32'h300, 32'h208, 32'h400);
        expect_out("R4", 32'h300, 32'h0000_FFFF, 3, 0);
        step("R2", 32'h304);
        step("R5", 32'h400);
        expect_out("R5", 32'h208, 32'hFFFF_0000, 2, 0);
        step("R2", 32'h20C);
        step("R6", 32'h400);
        expect_out("R6", 32'h400, 32'hFFFF_FFFF, 1, 0);
        // R7: taken path begins at the rejoin point, only not-taken is pushed
        branch("R7", 32'h1, 32'h500, 32'h404, 32'h500);
        expect_out("R7", 32'h404, 32'hFFFF_FFFE, 2, 0);
        step("R7", 32'h500);
        expect_out("R7", 32'h500, 32'hFFFF_FFFF, 1, 0);
        // R8: nested split sharing its parent's rejoin point replaces the top
        branch("R8", 32'h0F, 32'h600, 32'h504, 32'h700);
        branch("R8", 32'h03, 32'h640, 32'h610, 32'h700);
        expect_out("R8", 32'h640, 32'h3, 4, 0);
        step("R8", 32'h700);  expect_out("R8", 32'h610, 32'hC, 3, 0);
        step("R8", 32'h700);  expect_out("R8", 32'h504, 32'hFFFF_FFF0, 2, 0);
        step("R8", 32'h700);  expect_out("R8", 32'h700, 32'hFFFF_FFFF, 1, 0);
        // R11: inactive taken bits do not turn a uniform branch into a split
        branch("R11", 32'hF0, 32'h800, 32'h704, 32'h900);
        branch("R11", 32'hFFFF_00F0, 32'h840, 32'h810, 32'h880);
        expect_out("R11", 32'h840, 32'h0000_00F0, 3, 0);
        step("R11", 32'h900);
        step("R11", 32'h900);
        expect_out("R11", 32'h900, 32'hFFFF_FFFF, 1, 0);
        // R10: branch wins over a simultaneous step
        cyc("R10", 1, 32'h950, 1, 32'hFFFF_FFFF, 32'hA00, 32'h904, 32'hB00);
        expect_out("R10", 32'hA00, 32'hFFFF_FFFF, 1, 0);
        // R9: overflow with saturation and stickiness
        branch("R9", 32'h3, 32'hB00, 32'hA04, 32'hC00);
        branch("R9", 32'h1, 32'hB40, 32'hB10, 32'hB80);
        expect_out("R9", 32'hB10, 32'h2, 4, 1);
        step("R9", 32'hB14);
        expect_out("R9", 32'hB14, 32'h2, 4, 1);

        // randomized traffic against the reference model
        void'($urandom(32'h5EED));
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [31:0] m;
            if (n % 250 == 0) do_reset();
            sel = $urandom % 4;
            case ($urandom % 4)
                0: m = 32'hFFFF_FFFF;
                1: m = 32'h0;
                default: m = $urandom;
            endcase
            if (sel == 0) step("R2", rpc_pick());
            else if (sel == 3) cyc("R10", 1, rpc_pick(), 1, m, rpc_pick(), rpc_pick(), rpc_pick());
            else branch("R4", m, rpc_pick(), rpc_pick(), rpc_pick());
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule